// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of virtual-page to physical-frame translations. Each entry holds a valid flag, the identifier of the address space that owns it, a page number and a frame number. A lookup presents a page number and the current address-space identifier. Every entry is compared at the same time. One clock later the block reports hit or miss, and on a hit it also gives the frame number that the requester joins with its page offset. An entry matches only when its valid flag is set and both the page and the identifier agree. Because of this, translations that belong to different processes can be held together, and a context switch does not have to empty the cache.

On a miss the requester walks the in-memory page table by its own means and then writes the result back through the install port. An install for a page/identifier pair that is already present rewrites that entry. Otherwise the lowest-numbered empty entry is used, and when no entry is empty a round-robin pointer chooses the entry to replace. Maintenance commands invalidate, in a single cycle, either every entry that carries a given identifier or the whole cache.

A small state machine controls the response. It sits in `RSP_IDLE` when no result is being shown and in `RSP_SHOW` during the cycle after a lookup request. The transitions are:
- any state to `RSP_SHOW` when a lookup is requested
- any state to `RSP_IDLE` when no lookup is requested

Each cycle, update commands are decoded by priority into one operation: `OP_NONE`, `OP_FLUSH_ALL`, `OP_FLUSH_ASID` or `OP_INSTALL`.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low, so any lookup misses.
- R2: `rsp_valid` is high in exactly the cycle that follows a cycle with `lk_req` high, and it is low in every other cycle.
- R3: A lookup hits only when a valid entry holds the same page and the same identifier. On a hit `rsp_frame` carries the stored frame. On a miss `rsp_hit` is 0 and `rsp_frame` is 0.
- R4: Entries with the same page but different identifiers can be present together, and each lookup returns the frame of its own identifier.
- R5: An install whose page and identifier match a valid entry overwrites that entry's frame in place. No second copy is created and no other entry is disturbed, so at most one entry ever matches a lookup.
- R6: An install of a new pair fills the lowest-indexed invalid entry, including holes left by a flush, before any valid entry is replaced. When every entry is valid, the victim is the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, only on each such replacement.
- R7: A flush by identifier invalidates every entry with that identifier in one cycle and leaves all other entries intact. A lookup in the next cycle already misses on them.
- R8: A flush-all invalidates every entry in one cycle.
- R9: When several update commands arrive in one cycle, flush-all takes precedence over flush-by-identifier, which takes precedence over install. The install is dropped if any flush is present. A lookup in the same cycle as an update sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Identifier of the current address space |
| lk_page | input | PAGE_W | Page number to translate |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_frame | output | FRAME_W | Translated frame number; zero on a miss |
| ins_req | input | 1 | Install a translation |
| ins_asid | input | ASID_W | Identifier of the translation being installed |
| ins_page | input | PAGE_W | Page number being installed |
| ins_frame | input | FRAME_W | Frame number being installed |
| fl_asid_req | input | 1 | Invalidate all entries of one identifier |
| fl_asid | input | ASID_W | Identifier to invalidate |
| fl_all_req | input | 1 | Invalidate every entry |

## Verification
The assertions check on every cycle that the response arrives exactly one cycle after each request, that a miss carries a zero frame, and that no lookup ever matches more than one entry. They also check that after a flush-all no entry stays valid, and that after a flush by identifier no valid entry keeps that identifier. Only the bench scenarios can show which entry the round-robin pointer evicts and that holes are refilled before a replacement. The same applies to the coexistence of identical pages under different identifiers, to in-place overwrites, and to the ordering of commands that arrive in the same cycle. Each of these becomes visible only through the sequence of later lookup results.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // response state: showing a registered lookup result or not
    typedef enum logic [0:0] {
        RSP_IDLE = 1'b0,
        RSP_SHOW = 1'b1
    } rsp_state_e;

    // update operation selected for the current cycle
    typedef enum logic [1:0] {
        OP_NONE       = 2'd0,
        OP_FLUSH_ALL  = 2'd1,
        OP_FLUSH_ASID = 2'd2,
        OP_INSTALL    = 2'd3
    } upd_op_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 8,
    parameter int ASID_W = 8,
    parameter int PAGE_W = 20,
    parameter int IDX_W  = 3
) (
    input  logic [N-1:0]             valid_i,
    input  logic [N-1:0][ASID_W-1:0] asid_i,
    input  logic [N-1:0][PAGE_W-1:0] page_i,
    input  logic [ASID_W-1:0]        key_asid,
    input  logic [PAGE_W-1:0]        key_page,
    output logic [N-1:0]             hit_vec_o,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         hit_idx_o
);

    // parallel comparators, one per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g]
                            && (asid_i[g] == key_asid)
                            && (page_i[g] == key_page);
    end

    assign hit_o = |hit_vec_o;

    // OR-encode the (at most one-hot) match vector
    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec_o[i]) begin
                hit_idx_o = hit_idx_o | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_i,
    input  logic             advance_i,
    output logic [IDX_W-1:0] victim_o,
    output logic             full_o
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;

    // lowest-indexed empty slot
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    assign full_o   = !have_free;
    assign victim_o = have_free ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance_i) begin
            if (rr_q == IDX_W'(N - 1)) begin
                rr_q <= '0;
            end else begin
                rr_q <= rr_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N       = 8,
    parameter int ASID_W  = 8,
    parameter int PAGE_W  = 20,
    parameter int FRAME_W = 16,
    parameter int IDX_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  upd_op_e                   op_i,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [ASID_W-1:0]         wr_asid,
    input  logic [PAGE_W-1:0]         wr_page,
    input  logic [FRAME_W-1:0]        wr_frame,
    input  logic [ASID_W-1:0]         kill_asid,
    output logic [N-1:0]              valid_o,
    output logic [N-1:0][ASID_W-1:0]  asid_o,
    output logic [N-1:0][PAGE_W-1:0]  page_o,
    output logic [N-1:0][FRAME_W-1:0] frame_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= '0;
            asid_o  <= '0;
            page_o  <= '0;
            frame_o <= '0;
        end else begin
            unique case (op_i)
                OP_NONE: begin
                end
                OP_FLUSH_ALL: begin
                    valid_o <= '0;
                end
                OP_FLUSH_ASID: begin
                    for (int i = 0; i < N; i++) begin
                        if (asid_o[i] == kill_asid) begin
                            valid_o[i] <= 1'b0;
                        end
                    end
                end
                OP_INSTALL: begin
                    valid_o[wr_idx] <= 1'b1;
                    asid_o[wr_idx]  <= wr_asid;
                    page_o[wr_idx]  <= wr_page;
                    frame_o[wr_idx] <= wr_frame;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8,
    parameter int PAGE_W  = 20,
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic [PAGE_W-1:0]  lk_page,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [FRAME_W-1:0] rsp_frame,
    input  logic               ins_req,
    input  logic [ASID_W-1:0]  ins_asid,
    input  logic [PAGE_W-1:0]  ins_page,
    input  logic [FRAME_W-1:0] ins_frame,
    input  logic               fl_asid_req,
    input  logic [ASID_W-1:0]  fl_asid,
    input  logic               fl_all_req
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]              valid_vec;
    logic [ENTRIES-1:0][ASID_W-1:0]  asid_arr;
    logic [ENTRIES-1:0][PAGE_W-1:0]  page_arr;
    logic [ENTRIES-1:0][FRAME_W-1:0] frame_arr;

    logic [ENTRIES-1:0] lk_hit_vec;
    logic               lk_hit;
    logic [IDX_W-1:0]   lk_idx;

    logic [ENTRIES-1:0] in_hit_vec;
    logic               in_hit;
    logic [IDX_W-1:0]   in_idx;

    logic [IDX_W-1:0]   victim_idx;
    logic               tlb_full;
    logic [IDX_W-1:0]   wr_idx;
    logic               rr_advance;

    upd_op_e            op;
    rsp_state_e         state_q;
    rsp_state_e         state_d;
    logic               rsp_hit_q;
    logic [FRAME_W-1:0] rsp_frame_q;

    // ---------------- lookup compare ----------------
    tlb_match #(
        .N(ENTRIES), .ASID_W(ASID_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
    ) u_lk_match (
        .valid_i   (valid_vec),
        .asid_i    (asid_arr),
        .page_i    (page_arr),
        .key_asid  (lk_asid),
        .key_page  (lk_page),
        .hit_vec_o (lk_hit_vec),
        .hit_o     (lk_hit),
        .hit_idx_o (lk_idx)
    );

    // ---------------- install compare (duplicate detection) ----------------
    tlb_match #(
        .N(ENTRIES), .ASID_W(ASID_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
    ) u_in_match (
        .valid_i   (valid_vec),
        .asid_i    (asid_arr),
        .page_i    (page_arr),
        .key_asid  (ins_asid),
        .key_page  (ins_page),
        .hit_vec_o (in_hit_vec),
        .hit_o     (in_hit),
        .hit_idx_o (in_idx)
    );

    // ---------------- update decode by priority ----------------
    always_comb begin
        if (fl_all_req) begin
            op = OP_FLUSH_ALL;
        end else if (fl_asid_req) begin
            op = OP_FLUSH_ASID;
        end else if (ins_req) begin
            op = OP_INSTALL;
        end else begin
            op = OP_NONE;
        end
    end

    assign rr_advance = (op == OP_INSTALL) && !in_hit && tlb_full;
    assign wr_idx     = in_hit ? in_idx : victim_idx;

    tlb_victim #(
        .N(ENTRIES), .IDX_W(IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_vec),
        .advance_i (rr_advance),
        .victim_o  (victim_idx),
        .full_o    (tlb_full)
    );

    tlb_store #(
        .N(ENTRIES), .ASID_W(ASID_W), .PAGE_W(PAGE_W),
        .FRAME_W(FRAME_W), .IDX_W(IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .wr_idx    (wr_idx),
        .wr_asid   (ins_asid),
        .wr_page   (ins_page),
        .wr_frame  (ins_frame),
        .kill_asid (fl_asid),
        .valid_o   (valid_vec),
        .asid_o    (asid_arr),
        .page_o    (page_arr),
        .frame_o   (frame_arr)
    );

    // ---------------- response state machine ----------------
    always_comb begin
        unique case (state_q)
            RSP_IDLE: state_d = lk_req ? RSP_SHOW : RSP_IDLE;
            RSP_SHOW: state_d = lk_req ? RSP_SHOW : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit_q   <= 1'b0;
            rsp_frame_q <= '0;
        end else if (lk_req) begin
            rsp_hit_q   <= lk_hit;
            rsp_frame_q <= lk_hit ? frame_arr[lk_idx] : '0;
        end
    end

    assign rsp_valid = (state_q == RSP_SHOW);
    assign rsp_hit   = rsp_hit_q;
    assign rsp_frame = rsp_frame_q;

endmodule

// File: rtl/tlb_sva.sv
module tlb_sva #(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 8,
    parameter int FRAME_W = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             lk_req,
    input logic                             rsp_valid,
    input logic                             rsp_hit,
    input logic [FRAME_W-1:0]               rsp_frame,
    input logic                             fl_all_req,
    input logic                             fl_asid_req,
    input logic [ASID_W-1:0]                fl_asid,
    input logic [ENTRIES-1:0]               valid_vec,
    input logic [ENTRIES-1:0][ASID_W-1:0]   asid_arr,
    input logic [ENTRIES-1:0]               lk_hit_vec
);

    logic [ASID_W-1:0] fa_q;
    logic              leftover;

    always_ff @(posedge clk) begin
        fa_q <= fl_asid;
    end

    always_comb begin
        leftover = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid_vec[i] && (asid_arr[i] == fa_q)) begin
                leftover = 1'b1;
            end
        end
    end

    p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    p_rsp_only_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_frame == '0));

    p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lk_hit_vec) <= 1);

    p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all_req |=> (valid_vec == '0));

    p_flush_asid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_asid_req && !fl_all_req) |=> !leftover);

endmodule

bind asid_tlb tlb_sva #(
    .ENTRIES(ENTRIES), .ASID_W(ASID_W), .FRAME_W(FRAME_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_req      (lk_req),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_frame   (rsp_frame),
    .fl_all_req  (fl_all_req),
    .fl_asid_req (fl_asid_req),
    .fl_asid     (fl_asid),
    .valid_vec   (valid_vec),
    .asid_arr    (asid_arr),
    .lk_hit_vec  (lk_hit_vec)
);

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic [19:0] lk_page = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [15:0] rsp_frame;
    logic        ins_req = 1'b0;
    logic [7:0]  ins_asid = '0;
    logic [19:0] ins_page = '0;
    logic [15:0] ins_frame = '0;
    logic        fl_asid_req = 1'b0;
    logic [7:0]  fl_asid = '0;
    logic        fl_all_req = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    asid_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_asid(lk_asid), .lk_page(lk_page),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame),
        .ins_req(ins_req), .ins_asid(ins_asid), .ins_page(ins_page),
        .ins_frame(ins_frame),
        .fl_asid_req(fl_asid_req), .fl_asid(fl_asid), .fl_all_req(fl_all_req)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // lookup with response check one cycle later, then idle check
    task automatic lookup(input logic [7:0] a, input logic [19:0] p,
                          input logic eh, input logic [15:0] ef, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_asid = a; lk_page = p;
        @(negedge clk);
        lk_req = 1'b0;
        chk(rsp_valid == 1'b1, "R2 rsp_valid after request", 32'(rsp_valid), 32'd1);
        chk(rsp_hit == eh, tag, 32'(rsp_hit), 32'(eh));
        chk(rsp_frame == (eh ? ef : 16'h0), tag, 32'(rsp_frame), 32'(eh ? ef : 16'h0));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2 rsp_valid drops", 32'(rsp_valid), 32'd0);
    endtask

    task automatic install(input logic [7:0] a, input logic [19:0] p, input logic [15:0] f);
        @(negedge clk);
        ins_req = 1'b1; ins_asid = a; ins_page = p; ins_frame = f;
        @(negedge clk);
        ins_req = 1'b0;
    endtask

    task automatic flush_all();
        @(negedge clk);
        fl_all_req = 1'b1;
        @(negedge clk);
        fl_all_req = 1'b0;
    endtask

    task automatic flush_id(input logic [7:0] a);
        @(negedge clk);
        fl_asid_req = 1'b1; fl_asid = a;
        @(negedge clk);
        fl_asid_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        lookup(8'd0, 20'h0, 1'b0, 16'h0, "R1 empty after reset");
        lookup(8'd5, 20'h10, 1'b0, 16'h0, "R1 empty after reset 2");
    endtask

    // R6: fill order, round-robin eviction, hole refill
    task automatic t_replace();
        for (int i = 0; i < 8; i++) install(8'd5, 20'h10 + 20'(i), 16'h200 + 16'(i));
        install(8'd5, 20'h18, 16'h300);
        install(8'd5, 20'h19, 16'h301);
        lookup(8'd5, 20'h10, 1'b0, 16'h0, "R6 entry0 evicted first");
        lookup(8'd5, 20'h11, 1'b0, 16'h0, "R6 entry1 evicted second");
        lookup(8'd5, 20'h12, 1'b1, 16'h202, "R6 entry2 kept");
        lookup(8'd5, 20'h18, 1'b1, 16'h300, "R6 replacement hit");
        lookup(8'd5, 20'h19, 1'b1, 16'h301, "R6 replacement hit 2");
        // hole after flush is used before any valid entry
        flush_all();
        install(8'd7, 20'h30, 16'h400);
        for (int i = 1; i < 8; i++) install(8'd5, 20'h30 + 20'(i), 16'h400 + 16'(i));
        flush_id(8'd7);
        install(8'd5, 20'h40, 16'h440);
        for (int i = 1; i < 8; i++)
            lookup(8'd5, 20'h30 + 20'(i), 1'b1, 16'h400 + 16'(i), "R6 hole refilled, no eviction");
        lookup(8'd5, 20'h40, 1'b1, 16'h440, "R6 hole install hit");
    endtask

    task automatic t_asid();
        flush_all();
        install(8'd1, 20'h100, 16'hAAA);
        install(8'd2, 20'h100, 16'hBBB);
        lookup(8'd1, 20'h100, 1'b1, 16'hAAA, "R4 asid1 own frame");
        lookup(8'd2, 20'h100, 1'b1, 16'hBBB, "R4 asid2 own frame");
        lookup(8'd3, 20'h100, 1'b0, 16'h0, "R3 asid mismatch misses");
        lookup(8'd1, 20'h101, 1'b0, 16'h0, "R3 page mismatch misses");
    endtask

    task automatic t_overwrite();
        flush_all();
        install(8'd1, 20'h50, 16'h1);
        install(8'd1, 20'h51, 16'h2);
        install(8'd1, 20'h50, 16'h9);
        for (int i = 2; i < 8; i++) install(8'd1, 20'h50 + 20'(i), 16'h10 + 16'(i));
        lookup(8'd1, 20'h50, 1'b1, 16'h9, "R5 overwritten frame");
        lookup(8'd1, 20'h51, 1'b1, 16'h2, "R5 neighbour intact");
        for (int i = 2; i < 8; i++)
            lookup(8'd1, 20'h50 + 20'(i), 1'b1, 16'h10 + 16'(i), "R5 no duplicate consumed a slot");
    endtask

    task automatic t_flush_asid();
        flush_all();
        install(8'd1, 20'h60, 16'h61);
        install(8'd2, 20'h60, 16'h62);
        install(8'd1, 20'h63, 16'h64);
        flush_id(8'd1);
        lookup(8'd1, 20'h60, 1'b0, 16'h0, "R7 flushed asid misses");
        lookup(8'd1, 20'h63, 1'b0, 16'h0, "R7 flushed asid misses 2");
        lookup(8'd2, 20'h60, 1'b1, 16'h62, "R7 other asid kept");
    endtask

    task automatic t_flush_all();
        install(8'd4, 20'h66, 16'h77);
        flush_all();
        lookup(8'd4, 20'h66, 1'b0, 16'h0, "R8 flush all clears");
        lookup(8'd2, 20'h60, 1'b0, 16'h0, "R8 flush all clears 2");
    endtask

    task automatic t_priority();
        flush_all();
        install(8'd1, 20'h70, 16'h3);
        // flush-by-id + install + lookup in one cycle
        @(negedge clk);
        fl_asid_req = 1'b1; fl_asid = 8'd1;
        ins_req = 1'b1; ins_asid = 8'd2; ins_page = 20'h71; ins_frame = 16'h5;
        lk_req = 1'b1; lk_asid = 8'd1; lk_page = 20'h70;
        @(negedge clk);
        fl_asid_req = 1'b0; ins_req = 1'b0; lk_req = 1'b0;
        chk(rsp_hit == 1'b1, "R9 lookup sees pre-update contents", 32'(rsp_hit), 32'd1);
        chk(rsp_frame == 16'h3, "R9 lookup frame pre-update", 32'(rsp_frame), 32'h3);
        lookup(8'd2, 20'h71, 1'b0, 16'h0, "R9 install dropped under flush");
        lookup(8'd1, 20'h70, 1'b0, 16'h0, "R9 flush applied");
        // flush-all + flush-by-id + install in one cycle
        install(8'd4, 20'h74, 16'h8);
        @(negedge clk);
        fl_all_req = 1'b1; fl_asid_req = 1'b1; fl_asid = 8'd9;
        ins_req = 1'b1; ins_asid = 8'd3; ins_page = 20'h72; ins_frame = 16'h6;
        @(negedge clk);
        fl_all_req = 1'b0; fl_asid_req = 1'b0; ins_req = 1'b0;
        lookup(8'd4, 20'h74, 1'b0, 16'h0, "R9 flush all wins");
        lookup(8'd3, 20'h72, 1'b0, 16'h0, "R9 install dropped under flush all");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_replace();
        t_asid();
        t_overwrite();
        t_flush_asid();
        t_flush_all();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule